// File: doc/BRIEF.md
# Single-Cycle Sixteen-Bit Processor

This block is a small processor core that executes one instruction per clock. It has eight general registers of 16 bits each, a program counter, an instruction store and a data store. In each cycle it fetches the word at the program counter, decodes it, computes a result, and commits every effect at the next rising edge. Those effects are the register write-back, the data-store write, the status update and the new program counter.

Both stores are internal arrays. A test environment fills them directly while the core is held in reset. From outside, only the program counter and two status bits, negative and zero, are visible. Register contents can be brought out through the program counter with a register-indirect jump.

Each instruction word splits into four fields: a 7-bit opcode in bits 15:9, a destination field DR in bits 8:6, a first source field SA in bits 5:3, and a second source or operand field SB in bits 2:0.

Top module: `sc_proc16`

## Requirements
- R1: A synchronous reset clears the program counter, all eight registers and both status bits to 0.
- R2: The opcode sits in bits 15:9, DR in bits 8:6, SA in bits 5:3 and SB/operand in bits 2:0. One instruction completes per clock. Every instruction except a branch or jump adds one to the program counter.
- R3: The arithmetic opcodes write R[DR], wrapping modulo 2^16. MOVA (0000000) writes R[SA], INC (0000001) writes R[SA]+1, DEC (0000110) writes R[SA]-1, ADD (0000010) writes R[SA]+R[SB] and SUB (0000101) writes R[SA]-R[SB]. When DR equals SA, the old value is read and the new one is written in the same cycle.
- R4: The logic and move opcodes are AND 0001000, OR 0001001 and XOR 0001010, each on R[SA] and R[SB]. NOT (0001011) inverts R[SA] and MOVB (0001100) copies R[SB]. All write R[DR].
- R5: SHR (0001101) and SHL (0001110) write R[SB] moved by exactly one bit into R[DR]. The vacated bit is filled with 0.
- R6: LDI (1001100) writes the 3-bit SB field, zero-extended, into R[DR]. ADI (1000010) writes R[SA] plus that zero-extended field into R[DR].
- R7: LD (0010000) writes into R[DR] the data word at address R[SA]. ST (0100000) writes R[SB] into the data word at address R[SA] and writes no register. The address uses the low bits of R[SA].
- R8: BRZ (1100000) and BRN (1100001) take a 6-bit offset formed as {DR, SB} and sign-extend it. If R[SA] is zero (BRZ) or bit 15 of R[SA] is set (BRN), the program counter becomes the branch's own address plus the offset. Otherwise it advances by one. The stored status bits play no part in the decision.
- R9: JMP (1110000) loads the program counter with R[SA].
- R10: The R3 to R6 opcodes set N to bit 15 of the result and Z to 1 when the result is zero. LD, ST, BRZ, BRN and JMP leave both status bits unchanged.
- R11: An opcode not listed above changes no register, no data word and no status bit, and advances the program counter by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pcView | output | 16 | Current program counter, for halt and debug observation |
| flagN | output | 1 | Negative status from the last status-setting instruction |
| flagZ | output | 1 | Zero status from the last status-setting instruction |

## Verification
Two things share one cycle here. An instruction reads a register that the same instruction overwrites, and the status bits update on the same edge as the write-back. A chain of INC R1,R1 provokes the first case. Its count, brought out through JMP, must match the number of increments. Every swept ALU case judges the status bits against the result it just produced. A jump that follows must then leave those bits unchanged.

// File: rtl/sc_proc16_pkg.sv
package sc_proc16_pkg;

  localparam int INSTR_W = 16;
  localparam int OP_W    = 7;
  localparam int FLD_W   = 3;
  localparam int AD_W    = 2 * FLD_W;
  localparam int REG_CNT = 2 ** FLD_W;

  typedef enum logic [OP_W-1:0] {
    OP_MOVA = 7'b0000000,
    OP_INC  = 7'b0000001,
    OP_ADD  = 7'b0000010,
    OP_SUB  = 7'b0000101,
    OP_DEC  = 7'b0000110,
    OP_AND  = 7'b0001000,
    OP_OR   = 7'b0001001,
    OP_XOR  = 7'b0001010,
    OP_NOT  = 7'b0001011,
    OP_MOVB = 7'b0001100,
    OP_SHR  = 7'b0001101,
    OP_SHL  = 7'b0001110,
    OP_LD   = 7'b0010000,
    OP_ST   = 7'b0100000,
    OP_ADI  = 7'b1000010,
    OP_LDI  = 7'b1001100,
    OP_BRZ  = 7'b1100000,
    OP_BRN  = 7'b1100001,
    OP_JMP  = 7'b1110000
  } opcode_e;

  typedef enum logic [3:0] {
    ALU_PASSA, ALU_INC, ALU_ADD, ALU_SUB, ALU_DEC,
    ALU_AND, ALU_OR, ALU_XOR, ALU_NOT,
    ALU_PASSB, ALU_SHR, ALU_SHL
  } alu_op_e;

  typedef enum logic [1:0] {PC_SEQ, PC_BRZ, PC_BRN, PC_JMP} pc_sel_e;

  typedef struct packed {
    logic    regWrite;
    logic    memWrite;
    logic    memToReg;
    logic    useImm;
    logic    setFlags;
    alu_op_e aluOp;
    pc_sel_e pcSel;
  } ctrl_t;

endpackage

// File: rtl/sc_proc16_alu.sv
module sc_proc16_alu
  import sc_proc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       aluOp,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  output logic [DW-1:0] result
);

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    case (aluOp)
      ALU_PASSA: result = opA;
      ALU_INC:   result = opA + ONE;
      ALU_ADD:   result = opA + opB;
      ALU_SUB:   result = opA - opB;
      ALU_DEC:   result = opA - ONE;
      ALU_AND:   result = opA & opB;
      ALU_OR:    result = opA | opB;
      ALU_XOR:   result = opA ^ opB;
      ALU_NOT:   result = ~opA;
      ALU_PASSB: result = opB;
      ALU_SHR:   result = {1'b0, opB[DW-1:1]};
      ALU_SHL:   result = {opB[DW-2:0], 1'b0};
      default:   result = opA;
    endcase
  end

endmodule

// File: rtl/sc_proc16_ctrl.sv
module sc_proc16_ctrl
  import sc_proc16_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctrl_t           ctrlS
);

  always_comb begin
    ctrlS       = '0;
    ctrlS.aluOp = ALU_PASSA;
    ctrlS.pcSel = PC_SEQ;
    case (opcode)
      OP_MOVA: begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_PASSA; end
      OP_INC:  begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_INC;   end
      OP_ADD:  begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_ADD;   end
      OP_SUB:  begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_SUB;   end
      OP_DEC:  begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_DEC;   end
      OP_AND:  begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_AND;   end
      OP_OR:   begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_OR;    end
      OP_XOR:  begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_XOR;   end
      OP_NOT:  begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_NOT;   end
      OP_MOVB: begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_PASSB; end
      OP_SHR:  begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_SHR;   end
      OP_SHL:  begin ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1; ctrlS.aluOp = ALU_SHL;   end
      OP_LDI: begin
        ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1;
        ctrlS.useImm   = 1'b1; ctrlS.aluOp    = ALU_PASSB;
      end
      OP_ADI: begin
        ctrlS.regWrite = 1'b1; ctrlS.setFlags = 1'b1;
        ctrlS.useImm   = 1'b1; ctrlS.aluOp    = ALU_ADD;
      end
      OP_LD:  begin ctrlS.regWrite = 1'b1; ctrlS.memToReg = 1'b1; end
      OP_ST:  ctrlS.memWrite = 1'b1;
      OP_BRZ: ctrlS.pcSel = PC_BRZ;
      OP_BRN: ctrlS.pcSel = PC_BRN;
      OP_JMP: ctrlS.pcSel = PC_JMP;
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_proc16_dpath.sv
module sc_proc16_dpath
  import sc_proc16_pkg::*;
#(
  parameter int DW         = 16,
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrlS,
  output logic [OP_W-1:0] opcode,
  output logic [DW-1:0]   pc,
  output logic            flagN,
  output logic            flagZ
);

  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [INSTR_W-1:0] instrMem [IMEM_DEPTH];
  logic [DW-1:0]      dataMem  [DMEM_DEPTH];
  logic [DW-1:0]      regs     [REG_CNT];

  initial begin
    for (int i = 0; i < IMEM_DEPTH; i++) instrMem[i] = '0;
  end

  logic [INSTR_W-1:0] instr;
  logic [FLD_W-1:0]   drF, saF, sbF;
  logic [DW-1:0]      srcA, srcB, opB, aluY, wbData, memRd;
  logic [DW-1:0]      seqPc, brPc, nextPc;
  logic [AD_W-1:0]    adF;
  logic               brTaken;

  assign instr  = instrMem[pc[IAW-1:0]];
  assign opcode = instr[INSTR_W-1 -: OP_W];
  assign drF    = instr[3*FLD_W-1 -: FLD_W];
  assign saF    = instr[2*FLD_W-1 -: FLD_W];
  assign sbF    = instr[FLD_W-1:0];
  assign adF    = {drF, sbF};

  assign srcA = regs[saF];
  assign srcB = regs[sbF];
  assign opB  = ctrlS.useImm ? {{(DW-FLD_W){1'b0}}, sbF} : srcB;

  sc_proc16_alu #(.DW(DW)) u_alu (
    .aluOp (ctrlS.aluOp),
    .opA   (srcA),
    .opB   (opB),
    .result(aluY)
  );

  assign memRd  = dataMem[srcA[DAW-1:0]];
  assign wbData = ctrlS.memToReg ? memRd : aluY;

  // Next program counter
  assign seqPc = pc + ONE;
  assign brPc  = pc + {{(DW-AD_W){adF[AD_W-1]}}, adF};

  always_comb begin
    case (ctrlS.pcSel)
      PC_BRZ:  brTaken = (srcA == '0);
      PC_BRN:  brTaken = srcA[DW-1];
      default: brTaken = 1'b0;
    endcase
    if (ctrlS.pcSel == PC_JMP) nextPc = srcA;
    else if (brTaken)          nextPc = brPc;
    else                       nextPc = seqPc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      flagN <= 1'b0;
      flagZ <= 1'b0;
      for (int r = 0; r < REG_CNT; r++) regs[r] <= '0;
    end else begin
      pc <= nextPc;
      if (ctrlS.regWrite) regs[drF] <= wbData;
      if (ctrlS.setFlags) begin
        flagN <= aluY[DW-1];
        flagZ <= (aluY == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && ctrlS.memWrite) dataMem[srcA[DAW-1:0]] <= srcB;
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && !flagN && !flagZ));

  assert_pc_seq_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrlS.pcSel == PC_SEQ) |=> (pc == $past(pc) + ONE));

  assert_store_no_reg_R7: assert property (@(posedge clk) disable iff (rst)
    ctrlS.memWrite |-> !ctrlS.regWrite);

  assert_branch_fall_R8: assert property (@(posedge clk) disable iff (rst)
    ((ctrlS.pcSel == PC_BRZ && srcA != '0) || (ctrlS.pcSel == PC_BRN && !srcA[DW-1]))
    |=> (pc == $past(pc) + ONE));

  assert_jump_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrlS.pcSel == PC_JMP) |=> (pc == $past(srcA)));

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrlS.setFlags |=> $stable({flagN, flagZ}));

endmodule

// File: rtl/sc_proc16.sv
module sc_proc16
  import sc_proc16_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] pcView,
  output logic        flagN,
  output logic        flagZ
);

  ctrl_t           ctrlS;
  logic [OP_W-1:0] opcode;

  sc_proc16_ctrl u_ctrl (
    .opcode(opcode),
    .ctrlS (ctrlS)
  );

  sc_proc16_dpath #(
    .DW        (16),
    .IMEM_DEPTH(IMEM_DEPTH),
    .DMEM_DEPTH(DMEM_DEPTH)
  ) u_dpath (
    .clk   (clk),
    .rst   (rst),
    .ctrlS (ctrlS),
    .opcode(opcode),
    .pc    (pcView),
    .flagN (flagN),
    .flagZ (flagZ)
  );

endmodule

// File: tb/sc_proc16_bench.sv
module sc_proc16_bench;
  import sc_proc16_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pcView;
  logic        flagN, flagZ;
  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  sc_proc16 u_sc_proc16 (
    .clk   (clk),
    .rst   (rst),
    .pcView(pcView),
    .flagN (flagN),
    .flagZ (flagZ)
  );

  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                            16'hFFFF, 16'h1234, 16'hA5A5, 16'h0F0F};
  opcode_e regOps [12] = '{OP_MOVA, OP_INC, OP_ADD, OP_SUB, OP_DEC, OP_AND,
                           OP_OR, OP_XOR, OP_NOT, OP_MOVB, OP_SHR, OP_SHL};

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(logic [6:0] op, int dr, int sa, int sb);
    return {op, 3'(dr), 3'(sa), 3'(sb)};
  endfunction

  task automatic putI(int a, logic [15:0] w);
    u_sc_proc16.u_dpath.instrMem[a] = w;
  endtask

  task automatic putD(int a, logic [15:0] w);
    u_sc_proc16.u_dpath.dataMem[a] = w;
  endtask

  // hold reset for two edges, return at a falling edge with reset still high
  task automatic prep();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  // release reset, run n instructions, sample at the falling edge, re-assert reset
  task automatic exec(int n);
    rst = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
  endtask

  function automatic logic [15:0] refOp(logic [6:0] op, logic [15:0] a, logic [15:0] b);
    case (op)
      OP_MOVA: return a;
      OP_INC:  return a + 16'd1;
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_DEC:  return a - 16'd1;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_NOT:  return ~a;
      OP_MOVB: return b;
      OP_SHR:  return b >> 1;
      OP_SHL:  return b << 1;
      OP_LDI:  return b;
      OP_ADI:  return a + b;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string opTag(logic [6:0] op);
    case (op)
      OP_MOVA, OP_INC, OP_ADD, OP_SUB, OP_DEC: return "R3";
      OP_SHR, OP_SHL:                          return "R5";
      OP_LDI, OP_ADI:                          return "R6";
      default:                                 return "R4";
    endcase
  endfunction

  // R1 <- dmem[0], R2 <- dmem[1], R4 <- op, then JMP R4 exposes R4 on the PC
  task automatic aluRun(logic [6:0] op, logic [15:0] a, logic [15:0] b, int sbField,
                        logic [15:0] expY);
    prep();
    putD(0, a);
    putD(1, b);
    putI(0, enc(OP_LDI, 3, 0, 1));
    putI(1, enc(OP_LD, 1, 0, 0));
    putI(2, enc(OP_LD, 2, 3, 0));
    putI(3, enc(op, 4, 1, sbField));
    putI(4, enc(OP_JMP, 0, 4, 0));
    exec(5);
    chk({opTag(op), " result"}, pcView, expY);
    chk("R10 status from result", {14'b0, flagN, flagZ}, {14'b0, expY[15], expY == 16'h0});
  endtask

  initial begin
    // R1: reset state
    prep();
    chk("R1 pc after reset", pcView, 16'h0000);
    chk("R1 status after reset", {14'b0, flagN, flagZ}, 16'h0000);

    // R1: registers and status cleared by a later reset
    putI(0, enc(OP_LDI, 6, 0, 5));
    putI(1, enc(OP_LDI, 7, 0, 0));
    exec(2);
    chk("R10 LDI zero sets Z", {14'b0, flagN, flagZ}, 16'h0001);
    prep();
    chk("R1 status cleared", {14'b0, flagN, flagZ}, 16'h0000);
    chk("R1 pc cleared", pcView, 16'h0000);
    putI(0, enc(OP_ADI, 4, 6, 3));
    putI(1, enc(OP_JMP, 0, 4, 0));
    exec(2);
    chk("R1 register cleared", pcView, 16'h0003);

    // R2: one instruction per clock, PC steps by one
    prep();
    for (int k = 0; k < 6; k++) putI(k, enc(OP_LDI, k, 0, k));
    rst = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R2 pc step", pcView, 16'(k));
    end
    rst = 1'b1;

    // R3: read and write of the same register in one instruction
    prep();
    putI(0, enc(OP_LDI, 1, 0, 2));
    for (int k = 1; k <= 4; k++) putI(k, enc(OP_INC, 1, 1, 0));
    putI(5, enc(OP_JMP, 0, 1, 0));
    exec(6);
    chk("R3 INC chain same register", pcView, 16'd6);

    // R3, R4, R5: register operation sweep
    foreach (regOps[o]) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          aluRun(regOps[o], vals[i], vals[j], 2, refOp(regOps[o], vals[i], vals[j]));
        end
      end
    end

    // R6: immediate sweep
    for (int i = 0; i < 8; i++) begin
      for (int imm = 0; imm < 8; imm++) begin
        aluRun(OP_LDI, vals[i], 16'hFFFF, imm, refOp(OP_LDI, vals[i], 16'(imm)));
        aluRun(OP_ADI, vals[i], 16'hFFFF, imm, refOp(OP_ADI, vals[i], 16'(imm)));
      end
    end

    // R7: store then load back through several addresses
    for (int addr = 2; addr < 8; addr++) begin
      for (int i = 0; i < 8; i++) begin
        prep();
        putD(0, vals[i]);
        putD(addr, ~vals[i]);
        putI(0, enc(OP_LDI, 3, 0, addr));
        putI(1, enc(OP_LD, 1, 0, 0));
        putI(2, enc(OP_ST, 0, 3, 1));
        putI(3, enc(OP_LD, 5, 3, 0));
        putI(4, enc(OP_JMP, 0, 5, 0));
        exec(5);
        chk("R7 store then load", pcView, vals[i]);
        chk("R10 LD/ST/JMP keep status", {14'b0, flagN, flagZ}, 16'h0000);
      end
    end

    // R10: LD of a negative word leaves Z=1,N=0 from the LDI before it
    prep();
    putD(0, 16'h8000);
    putI(0, enc(OP_LDI, 3, 0, 0));
    putI(1, enc(OP_LD, 1, 3, 0));
    exec(2);
    chk("R10 LD keeps status", {14'b0, flagN, flagZ}, 16'h0001);

    // R8: branch sweep over register values and all offsets
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 8; i++) begin
        for (int off = -32; off < 32; off++) begin
          logic [6:0]  bop;
          logic [5:0]  ad;
          logic        taken;
          logic [15:0] expPc;
          bop   = (b == 0) ? OP_BRZ : OP_BRN;
          ad    = 6'(off);
          taken = (b == 0) ? (vals[i] == 16'h0) : vals[i][15];
          expPc = taken ? (16'd1 + 16'(off)) : 16'd2;
          prep();
          putD(0, vals[i]);
          putI(0, enc(OP_LD, 1, 0, 0));
          putI(1, enc(bop, ad[5:3], 1, ad[2:0]));
          exec(2);
          chk("R8 branch target", pcView, expPc);
        end
      end
    end

    // R8: branch ignores stored status (Z=1 from LDI, register nonzero)
    prep();
    putD(0, 16'h0005);
    putI(0, enc(OP_LD, 1, 0, 0));
    putI(1, enc(OP_LDI, 2, 0, 0));
    putI(2, enc(OP_BRZ, 1, 1, 0));
    exec(3);
    chk("R8 BRZ uses register not status", pcView, 16'd3);

    // R9: jump to an arbitrary register value
    prep();
    putD(0, 16'hBEEF);
    putI(0, enc(OP_LD, 2, 0, 0));
    putI(1, enc(OP_JMP, 0, 2, 0));
    exec(2);
    chk("R9 jump target", pcView, 16'hBEEF);

    // R11: unlisted opcodes act as no-ops
    prep();
    putD(0, 16'h7777);
    putI(0, enc(OP_LDI, 4, 0, 6));
    putI(1, enc(7'b0000011, 4, 4, 4));
    putI(2, enc(7'b1111111, 4, 0, 0));
    putI(3, enc(7'b0110000, 4, 0, 4));
    exec(4);
    chk("R11 pc steps over unlisted", pcView, 16'd4);
    chk("R11 status unchanged", {14'b0, flagN, flagZ}, 16'h0000);
    prep();
    putI(0, enc(OP_LDI, 4, 0, 6));
    putI(1, enc(7'b0000011, 4, 4, 4));
    putI(2, enc(7'b1111111, 4, 0, 0));
    putI(3, enc(OP_LD, 5, 0, 0));
    putI(4, enc(OP_JMP, 0, 4, 0));
    exec(5);
    chk("R11 register unchanged", pcView, 16'd6);
    prep();
    putI(0, enc(OP_JMP, 0, 5, 0));
    exec(1);
    chk("R11 R5 cleared by reset", pcView, 16'd0);
    prep();
    putI(0, enc(OP_LD, 5, 0, 0));
    putI(1, enc(OP_JMP, 0, 5, 0));
    exec(2);
    chk("R11 memory unchanged", pcView, 16'h7777);

    summary();
    $finish;
  end

endmodule